// File: doc/BRIEF.md
# Auto-Reload Down-Counting Timer Channel

This block is one timer channel that produces a periodic interrupt request. A free-running prescaler divides the system clock into ticks. While the run bit in the control register is set, a 16-bit down-counter loses one on every tick. When it is at zero and another tick arrives, the count would go below zero. The block treats that as an underflow.

On an underflow, three things happen in the same clock edge. The counter is refilled from the reload register, a snapshot register takes the same reload value, and a one-clock interrupt pulse is raised.

Software programs the period through a small word-addressed register port. With a reload value B and a prescaler divisor D, the interrupt repeats every (B+1)·(D+1) clocks. The block has no compare output and no single-shot mode.

Top module: `tmr_chan_top`

## Requirements
- R1: The prescaler runs whether or not the channel is enabled and produces one tick every PRE_DIV+1 clocks.
- R2: The counter changes only on a tick while control bit 20 is 1. When that bit is 0, the counter and the snapshot hold their values and irq_o stays low.
- R3: A reload value B gives an underflow on the tick after the count reaches zero. Consecutive irq_o pulses are therefore (B+1)·(PRE_DIV+1) clocks apart.
- R4: On an underflow, the counter and the snapshot register (address 2) both load the reload value. After a pulse, address 2 reads the reload value that was in force at that underflow.
- R5: irq_o is a registered output. It is high for exactly one clock per underflow and low at all other times.
- R6: Writing the reload register does not alter the count already running. The new value is used only from the next underflow on.
- R7: The register map is as follows.
  - Address 0: control, 32 bits, read/write.
  - Address 1: reload, the low 16 bits of the written word are kept and bits 31:16 read as 0.
  - Address 2: snapshot, read-only; writes to it are ignored.
  - Address 3: reads 0.
  - Reads are combinational. Writes take effect at the clock edge where bus_sel and bus_we are both 1.
- R8: After a synchronous active-low reset, the control, reload, snapshot and count registers are all 0, irq_o is low, and the prescaler holds PRE_DIV.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_o | output | 1 | One-clock interrupt pulse per underflow |

## Verification
The assertions take three things for granted:
- rst_n is low for at least one clock edge before any access.
- bus_addr and bus_wdata are stable while bus_sel is high.
- Only one register access is made per clock.

The stimulus drives the bus at falling edges and holds each access for a single cycle. It changes the run bit only between measurement windows. Interval checks are taken between two irq_o pulses, so they do not depend on the prescaler's phase when the run bit is set.

// File: rtl/tmr_pkg.sv
// Package: shared constants and the register selector type for the timer channel.
// Assumes a word-addressed port with four register slots.
package tmr_pkg;
    localparam int CNT_W   = 16;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 2;
    localparam int RUN_BIT = 20;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL   = 2'd0,
        REG_RELOAD = 2'd1,
        REG_SNAP   = 2'd2,
        REG_NONE   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/tmr_prescaler.sv
// Prescaler: a free-running down-counter that emits one tick each time it
// passes zero, then refills from DIV. Assumes DIV fits in DIV_W bits.
module tmr_prescaler #(
    parameter int DIV   = 1,
    parameter int DIV_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam logic [DIV_W-1:0] DIV_V = DIV_W'(DIV);

    logic [DIV_W-1:0] pre_q;

    // Divider state: count down, refill from the divisor when zero is passed.
    always_ff @(posedge clk) begin
        if (!rst_n)            pre_q <= DIV_V;
        else if (pre_q == '0)  pre_q <= DIV_V;
        else                   pre_q <= pre_q - 1'b1;
    end

    assign tick_o = (pre_q == '0);

    // R1: the divider value never exceeds the divisor.
    a_r1_pre_range: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= DIV_V);

    generate
        if (DIV > 0) begin : g_spaced
            // R1: with a nonzero divisor, ticks never come on consecutive clocks.
            a_r1_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/tmr_regs.sv
// Register file: holds the control word and the reload value, decodes
// writes, and muxes reads, including the snapshot supplied by the counter.
// Assumes at most one access per clock.
module tmr_regs
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [CNT_W-1:0]  snap_i,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              run_o,
    output logic [CNT_W-1:0]  reload_o
);
    logic [DATA_W-1:0] ctrl_q;
    logic [CNT_W-1:0]  reload_q;
    reg_sel_e          sel;
    logic              wr;

    assign sel = reg_sel_e'(bus_addr);
    assign wr  = bus_sel && bus_we;

    // Control register: a full word, only the run bit drives the counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                      ctrl_q <= '0;
        else if (wr && sel == REG_CTRL)  ctrl_q <= bus_wdata;
    end

    // Reload register: keeps the low half of the written word.
    always_ff @(posedge clk) begin
        if (!rst_n)                        reload_q <= '0;
        else if (wr && sel == REG_RELOAD)  reload_q <= bus_wdata[CNT_W-1:0];
    end

    // Read multiplexer, zero-extending the narrow registers.
    always_comb begin
        case (sel)
            REG_CTRL:   bus_rdata = ctrl_q;
            REG_RELOAD: bus_rdata = {{(DATA_W-CNT_W){1'b0}}, reload_q};
            REG_SNAP:   bus_rdata = {{(DATA_W-CNT_W){1'b0}}, snap_i};
            default:    bus_rdata = '0;
        endcase
    end

    assign run_o    = ctrl_q[RUN_BIT];
    assign reload_o = reload_q;

    // R7: a write to the reload slot lands on the next clock.
    a_r7_reload_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == 2'd1) |=> (reload_o == $past(bus_wdata[CNT_W-1:0])));

    // R6: the reload value moves only through a bus write.
    a_r6_reload_only_by_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && bus_addr == 2'd1) |=> $stable(reload_o));
endmodule

// File: rtl/tmr_counter.sv
// Counter: the down-count with a borrow bit, the snapshot register and the
// interrupt pulse. Assumes tick_i lasts one clock per prescaled period.
module tmr_counter
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] snap_o,
    output logic             irq_o
);
    logic [CNT_W:0]   cnt_q;
    logic [CNT_W-1:0] snap_q;
    logic             irq_q;
    logic [CNT_W:0]   cnt_dec;
    logic             step;
    logic             under;

    assign cnt_dec = cnt_q - 1'b1;
    assign step    = tick_i && run_i;
    assign under   = step && cnt_dec[CNT_W];

    // Count: step down on an enabled tick, refill from reload on borrow.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (under)  cnt_q <= {1'b0, reload_i};
        else if (step)   cnt_q <= cnt_dec;
    end

    // Snapshot: takes the reload value at each underflow.
    always_ff @(posedge clk) begin
        if (!rst_n)      snap_q <= '0;
        else if (under)  snap_q <= reload_i;
    end

    // Interrupt: a registered pulse, one clock per underflow.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= under;
    end

    assign snap_o = snap_q;
    assign irq_o  = irq_q;

    // R2: with the run bit clear, neither the count nor the snapshot moves.
    a_r2_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> ($stable(cnt_q) && $stable(snap_q)));

    // R5: a pulse only ever follows an enabled tick.
    a_r5_irq_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> $past(tick_i && run_i));

    // R4: at the pulse, the snapshot equals the freshly loaded count.
    a_r4_snap_tracks_count: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> (snap_q == cnt_q[CNT_W-1:0]));

    // R3: the stored count never holds a borrow.
    a_r3_no_negative: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_q[CNT_W]);
endmodule

// File: rtl/tmr_chan_top.sv
// Top: one auto-reload timer channel with its prescaler, register port and
// interrupt pulse. Assumes a synchronous active-low reset.
module tmr_chan_top
    import tmr_pkg::*;
#(
    parameter int PRE_DIV = 1,
    parameter int PRE_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o
);
    logic             tick;
    logic             run;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] snap;

    tmr_prescaler #(.DIV(PRE_DIV), .DIV_W(PRE_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    tmr_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .snap_i    (snap),
        .bus_rdata (bus_rdata),
        .run_o     (run),
        .reload_o  (reload)
    );

    tmr_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick),
        .run_i    (run),
        .reload_i (reload),
        .snap_o   (snap),
        .irq_o    (irq_o)
    );

    // R8: the pulse output is low in the first cycle out of reset.
    a_r8_quiet_after_reset: assert property (@(posedge clk)
        !rst_n |=> !irq_o);
endmodule

// File: tb/tb_tmr_chan_top.sv
module tb_tmr_chan_top;
    localparam int CLK_PERIOD = 10;
    localparam int PRE_DIV    = 1;
    localparam int TICK       = PRE_DIV + 1;
    localparam int NVEC       = 5;
    localparam logic [31:0] RUN = 32'h0010_0000;
    // Vectors: {reload value, expected clocks between pulses}.
    localparam int VEC [NVEC][2] = '{
        '{0, 1*TICK}, '{1, 2*TICK}, '{4, 5*TICK}, '{9, 10*TICK}, '{17, 18*TICK}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    tmr_chan_top #(.PRE_DIV(PRE_DIV)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One-cycle write, driven from a falling edge; returns at the next falling edge.
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Counts falling edges until irq_o is seen high (or the limit runs out).
    task automatic wait_irq(input int lim, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!irq_o && n < lim);
    endtask

    initial begin
        logic [31:0] d;
        int n;
        int hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: reset state.
        rd(2'd0, d); check("R8 ctrl", d, 0);
        rd(2'd1, d); check("R8 reload", d, 0);
        rd(2'd2, d); check("R8 snap", d, 0);
        check("R8 irq", {31'b0, irq_o}, 0);

        // R7: register map.
        wr(2'd1, 32'hABCD_1234);
        rd(2'd1, d); check("R7 reload low half", d, 32'h0000_1234);
        wr(2'd2, 32'h0000_5555);
        rd(2'd2, d); check("R7 snap read-only", d, 0);
        rd(2'd3, d); check("R7 empty slot", d, 0);
        wr(2'd0, 32'h8000_0001);
        rd(2'd0, d); check("R7 ctrl rw", d, 32'h8000_0001);

        // R2: bits other than 20 do not start the count.
        hi = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (irq_o) hi++;
        end
        check("R2 no pulse while off", hi, 0);

        // R3/R4: vector table of periods.
        for (int v = 0; v < NVEC; v++) begin
            wr(2'd0, 32'h0);
            wr(2'd1, VEC[v][0]);
            wr(2'd0, RUN);
            wait_irq(200, n);
            wait_irq(200, n);
            check($sformatf("R3 period reload=%0d", VEC[v][0]), n, VEC[v][1]);
            rd(2'd2, d);
            check("R4 snapshot", d, VEC[v][0]);
        end

        // R5: pulse lasts one clock, with reload 3.
        wr(2'd1, 32'd3);
        wait_irq(200, n);
        wait_irq(200, n);
        @(negedge clk);
        check("R5 pulse width", {31'b0, irq_o}, 0);
        hi = 1;
        for (int i = 0; i < 3*TICK; i++) begin
            @(negedge clk);
            if (irq_o) hi++;
        end
        check("R5 one pulse per period", hi, 1);

        // R6: a reload change mid-period applies only after the next underflow.
        wr(2'd1, 32'd5);
        wait_irq(200, n);
        wait_irq(200, n);
        check("R6 steady period", n, 6*TICK);
        wr(2'd1, 32'd2);
        wait_irq(200, n);
        check("R6 current period kept", n + 1, 6*TICK);
        rd(2'd2, d); check("R6 snapshot new value", d, 2);
        wait_irq(200, n);
        check("R6 new period", n, 3*TICK);

        // R2: stop; nothing moves.
        wr(2'd0, 32'h0);
        rd(2'd2, d);
        hi = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (irq_o) hi++;
        end
        check("R2 no pulse after stop", hi, 0);
        rd(2'd2, d); check("R2 snapshot held", d, 2);

        // R1: prescaler keeps running while stopped; restart with reload 0.
        wr(2'd1, 32'd0);
        wr(2'd0, RUN);
        wait_irq(200, n);
        wait_irq(200, n);
        check("R1 tick period", n, TICK);

        // R8: reset again in the middle of a run.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(2'd0, d); check("R8 ctrl after reset", d, 0);
        check("R8 irq after reset", {31'b0, irq_o}, 0);

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule